// File: doc/BRIEF.md
# Entropy Source Mode Controller

This block is the mode sequencer that sits in front of a random-number entropy source. Software writes a 2-bit command. The controller accepts the command only when it is resting in a stable state and refuses it everywhere else. It then steps through power-down, power-up, digital self-test, analog self-test, normal run and error. While it does so it reports a 4-bit state code, the most recently accepted command, and one-cycle pulses for "command finished" and "command refused".

When an accepted command needs the analog source, the controller first times a power-up sequence. A precharge window comes first, then a start pulse. Both lengths are programmable in microseconds, and a slow bit doubles every interval. A tick-per-microsecond parameter turns microseconds into clock cycles. When power-up ends, the controller enters the requested test or normal run. A test ends when the test datapath reports completion, and the controller then latches the active-high pass bits. A health failure from the entropy checks forces the error state.

Top module: `esrc_mode_ctrl`

## Requirements
- R1: After reset, state_code is 0000 (off), last_cmd is 00, and done_pulse, reject_pulse, prechg_on, pulse_on and test_res are all zero.
- R2: A write is accepted only while the state is off (0000), normal run (0011) or error (1010). Command 00 moves to power-down (0010) for one cycle and then to off. Commands 01, 10 and 11 move to power-up (0001).
- R3: A write in any other state raises reject_pulse for one cycle, one cycle after the write, and leaves last_cmd unchanged.
- R4: last_cmd takes the written value on an accepted write, and holds its value otherwise.
- R5: done_pulse is high for exactly the one cycle in which the state code first shows off or error. Entering normal run never raises it.
- R6: health_fail in power-up, digital test (0111), analog test (1011) or normal run moves the state to error on the next cycle. Error is kept until a command is accepted. health_fail in off has no effect.
- R7: At the end of power-up the state becomes 0111 for command 01, 1011 for command 10 and 0011 for command 11. A test state returns to off on the cycle after test_done.
- R8: test_res reads zero from an accepted write until the test completes. Digital pass bits (1 = pass) load into bits [DIG_W-1:0] at the end of a digital test. The analog pass bit loads into bit DIG_W at the end of an analog test. The other field stays zero.
- R9: Precharge setting 00/01/10/11 holds prechg_on high for 0/20/30/40 µs worth of TICKS_PER_US cycles, before any start pulse.
- R10: Start-pulse setting 00 suppresses pulse_on. Settings 01/10/11 drive pulse_on high from 10 µs into the pulse phase until 50/70/90 µs into it. prechg_on and pulse_on are never high together.
- R11: With cfg_slow set, every precharge and pulse interval is twice as long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_val | input | 2 | Command: 00 off, 01 digital test, 10 analog test, 11 run |
| health_fail | input | 1 | Health test failure from the entropy checks |
| test_done | input | 1 | Test datapath has finished the running test |
| test_pass_dig | input | DIG_W | Digital test pass bits, 1 = pass |
| test_pass_ana | input | 1 | Analog test pass bit, 1 = pass |
| cfg_pulse | input | 2 | Start-pulse length setting |
| cfg_prechg | input | 2 | Precharge length setting |
| cfg_slow | input | 1 | Doubles all power-up intervals |
| state_code | output | 4 | Current state code |
| last_cmd | output | 2 | Last accepted command |
| done_pulse | output | 1 | Command finished event |
| reject_pulse | output | 1 | Command refused event |
| prechg_on | output | 1 | Precharge drive to the analog source |
| pulse_on | output | 1 | Start pulse drive to the analog source |
| test_res | output | DIG_W+1 | Latched test results |

## Verification
The bench builds the controller with TICKS_PER_US = 2 and DIG_W = 8. At that rate a 90 µs interval doubled by the slow bit lasts only a few hundred cycles, so the bench can count the exact high time of every precharge and pulse setting, with and without the slow bit. An 8-bit digital result field is wide enough to show that distinct pass patterns land in the right bits and that the analog bit stays separate.

// File: rtl/esrc_pkg.sv
package esrc_pkg;

  typedef enum logic [3:0] {
    ST_OFF   = 4'b0000,
    ST_PWRUP = 4'b0001,
    ST_PWRDN = 4'b0010,
    ST_RUN   = 4'b0011,
    ST_TDIG  = 4'b0111,
    ST_ERR   = 4'b1010,
    ST_TANA  = 4'b1011
  } es_state_t;

  localparam logic [1:0] CMD_OFF = 2'b00;
  localparam logic [1:0] CMD_DIG = 2'b01;
  localparam logic [1:0] CMD_ANA = 2'b10;
  localparam logic [1:0] CMD_RUN = 2'b11;

  localparam int unsigned PULSE_RISE_US = 10;
  localparam int unsigned MAX_US        = 90;

  function automatic int unsigned prechg_us(input logic [1:0] sel);
    case (sel)
      2'b01:   return 20;
      2'b10:   return 30;
      2'b11:   return 40;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned pulse_fall_us(input logic [1:0] sel);
    case (sel)
      2'b01:   return 50;
      2'b10:   return 70;
      2'b11:   return 90;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/esrc_pwrup_timer.sv
module esrc_pwrup_timer
  import esrc_pkg::*;
#(
  parameter int unsigned TICKS_PER_US = 48
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       abort,
  input  logic [1:0] cfg_prechg,
  input  logic [1:0] cfg_pulse,
  input  logic       cfg_slow,
  output logic       prechg_on,
  output logic       pulse_on,
  output logic       finish
);

  localparam int unsigned MAX_CYC = 2 * MAX_US * TICKS_PER_US;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_PUL} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] pre_len;
  logic [CW-1:0] rise_len;
  logic [CW-1:0] fall_len;

  function automatic logic [CW-1:0] to_cyc(input int unsigned us, input logic slow);
    int unsigned c;
    c = us * TICKS_PER_US;
    if (slow) c = c * 2;
    return CW'(c);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      pre_len  <= '0;
      rise_len <= '0;
      fall_len <= '0;
      finish   <= 1'b0;
    end else begin
      finish <= 1'b0;
      if (abort) begin
        phase <= PH_IDLE;
        cnt   <= '0;
      end else if (start) begin
        phase    <= PH_PRE;
        cnt      <= '0;
        pre_len  <= to_cyc(prechg_us(cfg_prechg), cfg_slow);
        rise_len <= (cfg_pulse == 2'b00) ? '0 : to_cyc(PULSE_RISE_US, cfg_slow);
        fall_len <= to_cyc(pulse_fall_us(cfg_pulse), cfg_slow);
      end else begin
        case (phase)
          PH_PRE: begin
            if (cnt == pre_len) begin
              phase <= PH_PUL;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_PUL: begin
            if (cnt == fall_len) begin
              phase  <= PH_IDLE;
              cnt    <= '0;
              finish <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: cnt <= '0;
        endcase
      end
    end
  end

  assign prechg_on = (phase == PH_PRE) && (cnt < pre_len);
  assign pulse_on  = (phase == PH_PUL) && (cnt >= rise_len) && (cnt < fall_len);

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(prechg_on && pulse_on));

  a_r9_prechg_before_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_on) |-> !prechg_on && (phase == PH_PUL));

  a_r10_finish_from_pulse: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PUL) && (cnt == fall_len) && !abort && !start |=> finish);

endmodule

// File: rtl/esrc_result_reg.sv
module esrc_result_reg #(
  parameter int unsigned DIG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load_dig,
  input  logic             load_ana,
  input  logic [DIG_W-1:0] dig_in,
  input  logic             ana_in,
  output logic [DIG_W:0]   res_out
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      res_out <= '0;
    end else if (load_dig) begin
      res_out <= {1'b0, dig_in};
    end else if (load_ana) begin
      res_out <= {ana_in, {DIG_W{1'b0}}};
    end
  end

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clear |=> (res_out == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !clear && !load_dig && !load_ana |=> $stable(res_out));

endmodule

// File: rtl/esrc_mode_ctrl.sv
module esrc_mode_ctrl
  import esrc_pkg::*;
#(
  parameter int unsigned TICKS_PER_US = 48,
  parameter int unsigned DIG_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [1:0]       cmd_val,
  input  logic             health_fail,
  input  logic             test_done,
  input  logic [DIG_W-1:0] test_pass_dig,
  input  logic             test_pass_ana,
  input  logic [1:0]       cfg_pulse,
  input  logic [1:0]       cfg_prechg,
  input  logic             cfg_slow,
  output logic [3:0]       state_code,
  output logic [1:0]       last_cmd,
  output logic             done_pulse,
  output logic             reject_pulse,
  output logic             prechg_on,
  output logic             pulse_on,
  output logic [DIG_W:0]   test_res
);

  es_state_t st, nxt;
  logic      acc_ok, accept;
  logic      tmr_start, tmr_abort, tmr_fin;
  logic      load_dig, load_ana;

  assign acc_ok    = (st == ST_OFF) || (st == ST_RUN) || (st == ST_ERR);
  assign accept    = cmd_wr && acc_ok;
  assign tmr_start = accept && (cmd_val != CMD_OFF);
  assign tmr_abort = (st == ST_PWRUP) && health_fail;
  assign load_dig  = (st == ST_TDIG) && test_done && !health_fail;
  assign load_ana  = (st == ST_TANA) && test_done && !health_fail;

  always_comb begin
    nxt = st;
    if (accept) begin
      nxt = (cmd_val == CMD_OFF) ? ST_PWRDN : ST_PWRUP;
    end else begin
      case (st)
        ST_PWRDN: nxt = ST_OFF;
        ST_PWRUP: begin
          if (health_fail) nxt = ST_ERR;
          else if (tmr_fin) begin
            case (last_cmd)
              CMD_DIG: nxt = ST_TDIG;
              CMD_ANA: nxt = ST_TANA;
              default: nxt = ST_RUN;
            endcase
          end
        end
        ST_TDIG, ST_TANA: begin
          if (health_fail) nxt = ST_ERR;
          else if (test_done) nxt = ST_OFF;
        end
        ST_RUN: if (health_fail) nxt = ST_ERR;
        default: nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_OFF;
      last_cmd     <= CMD_OFF;
      done_pulse   <= 1'b0;
      reject_pulse <= 1'b0;
    end else begin
      st           <= nxt;
      done_pulse   <= (nxt != st) && ((nxt == ST_OFF) || (nxt == ST_ERR));
      reject_pulse <= cmd_wr && !acc_ok;
      if (accept) last_cmd <= cmd_val;
    end
  end

  assign state_code = st;

  esrc_pwrup_timer #(.TICKS_PER_US(TICKS_PER_US)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .start      (tmr_start),
    .abort      (tmr_abort),
    .cfg_prechg (cfg_prechg),
    .cfg_pulse  (cfg_pulse),
    .cfg_slow   (cfg_slow),
    .prechg_on  (prechg_on),
    .pulse_on   (pulse_on),
    .finish     (tmr_fin)
  );

  esrc_result_reg #(.DIG_W(DIG_W)) u_res (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .load_dig (load_dig),
    .load_ana (load_ana),
    .dig_in   (test_pass_dig),
    .ana_in   (test_pass_ana),
    .res_out  (test_res)
  );

  a_r3_reject: assert property (@(posedge clk) disable iff (rst)
    cmd_wr && !((state_code == ST_OFF) || (state_code == ST_RUN) || (state_code == ST_ERR))
    |=> reject_pulse && $stable(last_cmd));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !cmd_wr |=> $stable(last_cmd));

  a_r5_done_state: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> (state_code == ST_OFF) || (state_code == ST_ERR));

  a_r5_done_edge: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> state_code != $past(state_code));

  a_r6_to_err: assert property (@(posedge clk) disable iff (rst)
    health_fail && !cmd_wr &&
    ((state_code == ST_PWRUP) || (state_code == ST_TDIG) ||
     (state_code == ST_TANA) || (state_code == ST_RUN))
    |=> state_code == ST_ERR);

  a_r6_err_kept: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_ERR) && !cmd_wr |=> state_code == ST_ERR);

  a_r2_pwrdn_brief: assert property (@(posedge clk) disable iff (rst)
    state_code == ST_PWRDN |=> state_code == ST_OFF);

  a_r8_busy_zero: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_PWRUP) || (state_code == ST_TDIG) ||
    (state_code == ST_TANA) || (state_code == ST_PWRDN) |-> test_res == '0);

endmodule

// File: tb/tb_esrc_mode_ctrl.sv
module tb_esrc_mode_ctrl;

  localparam int unsigned TPU   = 2;
  localparam int unsigned DIG_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmd_wr = 1'b0;
  logic [1:0]       cmd_val = 2'b00;
  logic             health_fail = 1'b0;
  logic             test_done = 1'b0;
  logic [DIG_W-1:0] test_pass_dig = '0;
  logic             test_pass_ana = 1'b0;
  logic [1:0]       cfg_pulse = 2'b10;
  logic [1:0]       cfg_prechg = 2'b10;
  logic             cfg_slow = 1'b0;
  logic [3:0]       state_code;
  logic [1:0]       last_cmd;
  logic             done_pulse, reject_pulse, prechg_on, pulse_on;
  logic [DIG_W:0]   test_res;

  int nchk = 0;
  int nerr = 0;
  logic [3:0] exp_q[$];

  always #5 clk = ~clk;

  esrc_mode_ctrl #(.TICKS_PER_US(TPU), .DIG_W(DIG_W)) dut (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_val(cmd_val),
    .health_fail(health_fail), .test_done(test_done),
    .test_pass_dig(test_pass_dig), .test_pass_ana(test_pass_ana),
    .cfg_pulse(cfg_pulse), .cfg_prechg(cfg_prechg), .cfg_slow(cfg_slow),
    .state_code(state_code), .last_cmd(last_cmd), .done_pulse(done_pulse),
    .reject_pulse(reject_pulse), .prechg_on(prechg_on), .pulse_on(pulse_on),
    .test_res(test_res)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: every state change pops the next expected state code.
  initial begin
    logic [3:0] prev;
    logic [3:0] e;
    @(negedge clk);
    while (rst) @(negedge clk);
    prev = state_code;
    forever begin
      @(negedge clk);
      if (state_code != prev) begin
        if (exp_q.size() == 0) begin
          chk("R7 unexpected state change", int'(state_code), int'(prev));
        end else begin
          e = exp_q.pop_front();
          chk("R7 state sequence", int'(state_code), int'(e));
        end
        prev = state_code;
      end
    end
  end

  task automatic wr_cmd(input logic [1:0] c);
    @(negedge clk);
    cmd_wr  = 1'b1;
    cmd_val = c;
    @(negedge clk);
    cmd_wr  = 1'b0;
  endtask

  task automatic wait_state(input logic [3:0] s);
    int n = 0;
    while (state_code != s && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure(output int pc, output int pu);
    pc = 0;
    pu = 0;
    while (state_code == 4'b0001) begin
      if (prechg_on) pc++;
      if (pulse_on) pu++;
      @(negedge clk);
    end
  endtask

  task automatic finish_test(input logic [DIG_W-1:0] d, input logic a);
    @(negedge clk);
    test_done = 1'b1;
    test_pass_dig = d;
    test_pass_ana = a;
    @(negedge clk);
    test_done = 1'b0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int pc, pu;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 state", int'(state_code), 0);
    chk("R1 last_cmd", int'(last_cmd), 0);
    chk("R1 pulses", int'({done_pulse, reject_pulse, prechg_on, pulse_on}), 0);
    chk("R1 test_res", int'(test_res), 0);

    // Digital test, default timing
    exp_q.push_back(4'b0001); exp_q.push_back(4'b0111); exp_q.push_back(4'b0000);
    wr_cmd(2'b01);
    chk("R2 enter power-up", int'(state_code), 1);
    chk("R4 last_cmd on accept", int'(last_cmd), 1);
    measure(pc, pu);
    chk("R9 precharge 30us", pc, 30 * TPU);
    chk("R10 pulse 10..70us", pu, 60 * TPU);
    chk("R7 digital test state", int'(state_code), 4'b0111);
    wr_cmd(2'b11);
    chk("R3 reject pulse", int'(reject_pulse), 1);
    chk("R3 state kept", int'(state_code), 4'b0111);
    chk("R4 last_cmd kept on reject", int'(last_cmd), 1);
    chk("R8 zero while testing", int'(test_res), 0);
    @(negedge clk);
    chk("R3 reject one cycle", int'(reject_pulse), 0);
    finish_test(8'hA5, 1'b1);
    chk("R7 test returns off", int'(state_code), 0);
    chk("R5 done on off", int'(done_pulse), 1);
    chk("R8 digital bits", int'(test_res), 9'h0A5);
    @(negedge clk);
    chk("R5 done one cycle", int'(done_pulse), 0);

    // Analog test, no precharge, short pulse, slow
    cfg_prechg = 2'b00; cfg_pulse = 2'b01; cfg_slow = 1'b1;
    exp_q.push_back(4'b0001); exp_q.push_back(4'b1011); exp_q.push_back(4'b0000);
    wr_cmd(2'b10);
    chk("R8 cleared on accept", int'(test_res), 0);
    measure(pc, pu);
    chk("R9 precharge disabled", pc, 0);
    chk("R11 pulse doubled", pu, 40 * TPU * 2);
    chk("R7 analog test state", int'(state_code), 4'b1011);
    wr_cmd(2'b00);
    chk("R3 reject in analog test", int'(reject_pulse), 1);
    chk("R4 last_cmd kept", int'(last_cmd), 2);
    finish_test(8'hFF, 1'b1);
    chk("R8 analog bit only", int'(test_res), 9'h100);

    // Normal run, longest timing, then health failure
    cfg_prechg = 2'b11; cfg_pulse = 2'b11; cfg_slow = 1'b0;
    exp_q.push_back(4'b0001); exp_q.push_back(4'b0011); exp_q.push_back(4'b1010);
    wr_cmd(2'b11);
    measure(pc, pu);
    chk("R9 precharge 40us", pc, 40 * TPU);
    chk("R10 pulse 10..90us", pu, 80 * TPU);
    chk("R7 run state", int'(state_code), 4'b0011);
    chk("R5 no done entering run", int'(done_pulse), 0);
    repeat (5) @(negedge clk);
    chk("R5 run stays quiet", int'(done_pulse), 0);
    health_fail = 1'b1;
    @(negedge clk);
    chk("R6 run to error", int'(state_code), 4'b1010);
    chk("R5 done on error", int'(done_pulse), 1);
    @(negedge clk);
    health_fail = 1'b0;
    chk("R6 error kept", int'(state_code), 4'b1010);
    exp_q.push_back(4'b0010); exp_q.push_back(4'b0000);
    wr_cmd(2'b00);
    chk("R2 accepted in error", int'(state_code), 4'b0010);
    chk("R4 last_cmd off", int'(last_cmd), 0);
    @(negedge clk);
    chk("R2 power-down to off", int'(state_code), 0);
    chk("R5 done after power-down", int'(done_pulse), 1);

    // Health failure during power-up; ignored while off
    cfg_prechg = 2'b10; cfg_pulse = 2'b10;
    exp_q.push_back(4'b0001); exp_q.push_back(4'b1010);
    wr_cmd(2'b01);
    repeat (5) @(negedge clk);
    health_fail = 1'b1;
    @(negedge clk);
    health_fail = 1'b0;
    chk("R6 power-up to error", int'(state_code), 4'b1010);
    chk("R9 precharge stopped", int'({prechg_on, pulse_on}), 0);
    chk("R8 zero after failure", int'(test_res), 0);
    exp_q.push_back(4'b0010); exp_q.push_back(4'b0000);
    wr_cmd(2'b00);
    wait_state(4'b0000);
    @(negedge clk);
    health_fail = 1'b1;
    @(negedge clk);
    health_fail = 1'b0;
    chk("R6 ignored when off", int'(state_code), 0);
    chk("R6 no done when off", int'(done_pulse), 0);

    repeat (3) @(negedge clk);
    chk("R7 expected states all seen", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule